// File: doc/BRIEF.md
# Hamming Sector Check-Code Corrector

This block takes the two 3-byte Hamming check codes that belong to one 512-byte sector. One is the code stored in the spare area. The other is the code computed while the sector data streamed in. Each code is repacked into a 32-bit word that splits the parity into two 12-bit halves, and the two words are XORed into a syndrome. The block then counts the syndrome's set bits over its 24 meaningful positions and decides on one of five outcomes:

- the data is clean;
- a single data bit is in error and gets corrected;
- the check code itself is damaged;
- the page is erased;
- the error cannot be corrected.

For a correctable error, the block fixes the sector buffer in place. It reads the faulty byte through a one-cycle synchronous memory port, flips the bit, and writes the byte back. A start pulse begins the work, and a one-cycle done pulse returns a 2-bit status. The sector buffer and the parity generator are outside the block.

Top module: `ham_sector_fix`

## Requirements
- R1: After reset, `done`, `busy` and `mem_en` are low and `status` is 0.
- R2: Each code's bytes are taken as b0 = bits [7:0], b1 = bits [15:8] and b2 = bits [23:16]. A code repacks to a word with b0 in bits [7:0], the low nibble of b2 in bits [11:8], b1 in bits [23:16], the high nibble of b2 in bits [27:24], and zeros elsewhere. If the two repacked codes are equal (zero syndrome), status is 0 and the buffer is not accessed.
- R3: If exactly 12 syndrome bits are set, status is 1. The buffer byte at address syndrome[27:19] has bit syndrome[18:16] inverted, and all other bytes are left unchanged.
- R4: If exactly one syndrome bit is set, status is 2 and the buffer is not accessed.
- R5: A stored code that repacks to 0x0FFF0FFF (all bytes 0xFF), paired with a computed code of zero, gives status 0, and the buffer is not accessed.
- R6: Any other nonzero syndrome gives status 3, and the buffer is not accessed.
- R7: A start accepted while idle raises `busy` on the next cycle. `done` is a one-cycle pulse:
  - it comes on the third rising edge after the accepting edge for outcomes without a correction;
  - it comes on the fourth rising edge for a correction.
- R8: A start pulse is ignored while `busy` is high. `status` changes only on the edge that raises `done`, and holds until the next result.
- R9: A correction performs exactly one read, then exactly one write on the very next cycle to the same address. The write data is the read data XOR the one-hot bit mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; codes sampled on the same edge |
| stored_code | input | 24 | Check code read from the spare area (b2,b1,b0) |
| calc_code | input | 24 | Check code computed over the sector data (b2,b1,b0) |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| status | output | 2 | 0 clean/erased, 1 corrected, 2 code error, 3 uncorrectable |
| mem_en | output | 1 | Buffer access enable |
| mem_we | output | 1 | Buffer write enable (read when low) |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, valid one cycle after a read |

## Verification
The bench builds single-bit data errors for the edge addresses, byte 0 bit 0 and byte 511 bit 7, as well as random positions. A design that swapped the nibbles of byte 2 in the repacking, or took the wrong syndrome slice for the address, would flip the wrong byte or the wrong bit, and the full buffer comparison exposes it. The erased-page pattern is checked next to a near miss: all-ones stored against a computed code of one. A design that skipped the erased test would report code 3 on a blank page, while one that matched too loosely would hide a real fault. The bench also flips a single code bit, pulses start while busy, and checks that the buffer is never touched outside a correction.

// File: rtl/ham_sector_fix.sv
module ham_sector_fix (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] stored_code,
  input  logic [23:0] calc_code,
  output logic        busy,
  output logic        done,
  output logic [1:0]  status,
  output logic        mem_en,
  output logic        mem_we,
  output logic [8:0]  mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);

  localparam logic [31:0] ERASED_WORD = 32'h0FFF_0FFF;
  localparam int          PAIR_BITS   = 12;

  typedef enum logic [2:0] {S_IDLE, S_SUM1, S_SUM2, S_DEC, S_WR} state_t;

  function automatic logic [31:0] repack(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  state_t      state;
  logic [31:0] rp_st, rp_cl, syn;
  logic [2:0]  part [4];
  logic [4:0]  ones;
  logic [23:0] live;
  logic        correctable;
  logic [1:0]  verdict;

  assign live = {syn[27:16], syn[11:0]};
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rp_st  <= '0;
      rp_cl  <= '0;
      syn    <= '0;
      ones   <= '0;
      done   <= 1'b0;
      status <= 2'd0;
      for (int g = 0; g < 4; g++) part[g] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          rp_st <= repack(stored_code);
          rp_cl <= repack(calc_code);
          syn   <= repack(stored_code) ^ repack(calc_code);
          state <= S_SUM1;
        end
        S_SUM1: begin
          for (int g = 0; g < 4; g++)
            part[g] <= 3'($countones(live[g*6 +: 6]));
          state <= S_SUM2;
        end
        S_SUM2: begin
          ones  <= 5'(part[0]) + 5'(part[1]) + 5'(part[2]) + 5'(part[3]);
          state <= S_DEC;
        end
        S_DEC: begin
          if (correctable) state <= S_WR;
          else begin
            state  <= S_IDLE;
            done   <= 1'b1;
            status <= verdict;
          end
        end
        S_WR: begin
          state  <= S_IDLE;
          done   <= 1'b1;
          status <= 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign correctable = (syn != 32'd0) && (ones == 5'(PAIR_BITS));

  always_comb begin
    if (syn == 32'd0)                               verdict = 2'd0;
    else if (ones == 5'(PAIR_BITS))                 verdict = 2'd1;
    else if (ones == 5'd1)                          verdict = 2'd2;
    else if (rp_st == ERASED_WORD && rp_cl == '0)   verdict = 2'd0;
    else                                            verdict = 2'd3;
  end

  assign mem_en    = (state == S_DEC && correctable) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = syn[27:19];
  assign mem_wdata = mem_rdata ^ (8'h01 << syn[18:16]);

  p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));
  p_write_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_en && !mem_we));
  p_write_same_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == $past(mem_addr)));
  p_corrected_wrote_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> $past(mem_we));
  p_no_touch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd1) |-> !$past(mem_en));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

endmodule

// File: tb/ham_sector_fix_bench.sv
module ham_sector_fix_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic        busy, done, mem_en, mem_we;
  logic [1:0]  status;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] mem  [512];
  logic [7:0] gold [512];
  int n_rd, n_wr;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ham_sector_fix u_ham_sector_fix (
    .clk, .rst_n, .start, .stored_code, .calc_code, .busy, .done, .status,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin mem[mem_addr] <= mem_wdata; n_wr <= n_wr + 1; end
      else begin mem_rdata <= mem[mem_addr]; n_rd <= n_rd + 1; end
    end
  end

  function automatic logic [31:0] rp(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] unrp(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  function automatic logic [1:0] classify(input logic [23:0] st, input logic [23:0] cl);
    logic [31:0] s;
    int pc;
    s  = rp(st) ^ rp(cl);
    pc = $countones(s);
    if (s == 0)      return 2'd0;
    if (pc == 12)    return 2'd1;
    if (pc == 1)     return 2'd2;
    if (rp(st) == 32'h0FFF0FFF && rp(cl) == 0) return 2'd0;
    return 2'd3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] st, input logic [23:0] cl, input bit poke, input string tag);
    logic [1:0]  es;
    logic [31:0] s;
    int n, bad, lat;
    bit got;
    es = classify(st, cl);
    s  = rp(st) ^ rp(cl);
    if (es == 2'd1) gold[s[27:19]] = gold[s[27:19]] ^ (8'h01 << s[18:16]);
    n_rd = 0; n_wr = 0;
    @(negedge clk); stored_code = st; calc_code = cl; start = 1'b1;
    @(posedge clk); #1;
    n = 0; got = 0;
    for (int i = 0; i < 12 && !got; i++) begin
      @(negedge clk);
      start = poke && (i == 0);
      if (poke && i == 0) begin stored_code = ~st; calc_code = cl ^ 24'h000005; end
      @(posedge clk); #1;
      n++;
      if (done) got = 1;
    end
    start = 1'b0;
    chk(got, {tag, " R7 done seen"}, got, 1);
    chk(status == es, {tag, " status"}, status, es);
    lat = (es == 2'd1) ? 4 : 3;
    chk(n == lat, {tag, " R7 latency"}, n, lat);
    bad = 0;
    for (int a = 0; a < 512; a++) if (mem[a] !== gold[a]) bad++;
    chk(bad == 0, {tag, " buffer bytes differing"}, bad, 0);
    chk(n_wr == (es == 2'd1 ? 1 : 0) && n_rd == n_wr, {tag, " R9 access count"}, n_rd * 10 + n_wr,
        es == 2'd1 ? 11 : 0);
    @(posedge clk); #1;
    chk(!done, {tag, " R7 pulse width"}, done, 0);
    repeat (2) @(posedge clk); #1;
    chk(status == es, {tag, " R8 status held"}, status, es);
  endtask

  function automatic logic [23:0] make_single(input logic [23:0] st, input logic [8:0] byt, input logic [2:0] bt);
    logic [11:0] hi;
    hi = {byt, bt};
    return st ^ unrp({4'h0, hi, 4'h0, ~hi});
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [23:0] st;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 512; a++) begin
      gold[a] = 8'($urandom);
      mem[a]  = gold[a];
    end
    repeat (3) @(posedge clk); #1;
    chk(!done && !busy && !mem_en && status == 2'd0, "R1 reset state",
        {done, busy, mem_en, status}, 0);
    @(negedge clk); rst_n = 1'b1;

    run(24'h3C5A96, 24'h3C5A96, 0, "R2 equal codes");
    run(24'hFFFFFF, 24'h000000, 0, "R5 erased page");
    run(24'hFFFFFF, 24'h000001, 0, "R6 near-erased");
    run(24'h123456, make_single(24'h123456, 9'd0, 3'd0), 0, "R3 byte0 bit0");
    run(24'hA5A5A5, make_single(24'hA5A5A5, 9'd511, 3'd7), 0, "R3 byte511 bit7");
    run(24'h0F0F0F, 24'h0F0F0F ^ 24'h100000, 0, "R4 high nibble flip");
    run(24'h777777, make_single(24'h777777, 9'd300, 3'd2), 1, "R8 start while busy");
    run(24'h000000, 24'h00000F, 1, "R8 start while busy uncorrectable");

    for (int k = 0; k < 30; k++) begin
      st = 24'($urandom);
      run(st, make_single(st, 9'($urandom), 3'($urandom)), 0, "R3 random single");
    end
    for (int k = 0; k < 24; k++) begin
      st = 24'($urandom);
      run(st, st ^ (24'd1 << k), 0, "R4 code bit flip");
    end
    for (int k = 0; k < 30; k++) run(24'($urandom), 24'($urandom), 0, "R6 random pair");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule